// File: doc/BRIEF.md
# Thermal Trip Level Interrupt Unit

This block watches a stream of temperature codes from an on-chip sensor and raises an interrupt when the temperature climbs past one of four trip points. All four trip points share one base threshold code. Each level adds its own offset to that base, so software can set a whole ladder of warning, critical and emergency points by moving a single value. Each level has its own latched status bit and its own enable bit. A status bit is set only on the sample where its level is first exceeded. It then holds until software clears it.

The unit has a small register port with single-cycle writes and combinational reads. Through that port software configures a control word, the threshold, the four offsets and the enables. It reads back the current code, the four most recent samples, the status bits, a ready flag and a trim word. The sensor front end supplies each new code together with a one-cycle strobe. While the control word does not hold the core in the on state, every enable is forced off and no new trip is latched.

Top module: `thermal_trip_unit`

## Requirements
- R1: After a synchronous reset, every register that reads back holds zero and irq is low.
- R2: Offset 0x00 reads the trim_word input zero-extended. Offset 0x28 reads sense_ready in bit 0, and all other bits read zero.
- R3: While sense_ready is low, writes to control, threshold, the four offsets and interrupt enable have no effect. Writes to the clear register still act.
- R4: The control register at 0x20 holds a mode in bits [1:0], a 4-bit gain in bits [11:8] and a 5-bit reference field in bits [28:24]. It reads back exactly those fields. Mode 3 means the core is on. Any other mode means it is off.
- R5: Offset 0x40 reads the most recent strobed temperature code. Offset 0x44 holds the 8-bit threshold. Offsets 0x50, 0x54, 0x58 and 0x5C hold the 8-bit offsets for levels 0 to 3. Addresses that are not mapped read zero.
- R6: The trip point of a level is threshold plus offset, computed as a 9-bit sum that cannot wrap. A level is hot only when the sample is strictly greater than its trip point.
- R7: The status register at 0x74 has one bit per level, at bit 4×level. A bit is set on a strobe where the level is hot, the previous strobed sample was not hot for that level, and the core is on.
- R8: A status bit stays set until a write to 0x78 has a 1 in that level's bit (0x1111 clears all four). If a set and a clear fall in the same cycle, the set wins.
- R9: irq is high exactly when some status bit is set and its effective enable is set.
- R10: The interrupt enable register at 0x70 uses bits 0, 4, 8 and 12. It reads back the effective enables, which are all zero while the core is off.
- R11: On each strobe the history shifts. 0x60 takes the new sample, 0x64, 0x68 and 0x6C take the older ones, and the oldest value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_ready | input | 1 | Sensor ready; gates configuration writes |
| trim_word | input | 16 | Calibration word for read-back |
| temp_code | input | 8 | Current temperature code |
| temp_vld | input | 1 | One-cycle strobe marking a new temp_code |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Write enable for reg_wdata |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Level-high interrupt |

## Verification
A corrupted per-level "previous hot" flag shows up on the next strobe. The status bit either fails to set on a real crossing or sets again on a sustained high. A wrong sum width shows up as a false trip whenever threshold plus offset exceeds 255. A bad enable mask or a bad status latch changes irq in the same cycle it occurs. Because of this, a reference model compared on every clock catches the fault within one cycle of the stimulus that exposes it. Any register read back through reg_rdata is compared on every clock as well.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
    localparam int CODE_W   = 8;
    localparam int LEVELS   = 4;
    localparam int HIST_D   = 4;
    localparam int GAIN_W   = 4;
    localparam int VREF_W   = 5;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int TRIM_W   = 16;
    localparam int NIB      = 4;
    localparam int GAIN_LSB = 8;
    localparam int VREF_LSB = 24;

    localparam logic [ADDR_W-1:0] A_TRIM  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] A_RDY   = 8'h28;
    localparam logic [ADDR_W-1:0] A_CUR   = 8'h40;
    localparam logic [ADDR_W-1:0] A_THR   = 8'h44;
    localparam logic [ADDR_W-1:0] A_OFS0  = 8'h50;
    localparam logic [ADDR_W-1:0] A_HIST0 = 8'h60;
    localparam logic [ADDR_W-1:0] A_EN    = 8'h70;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h74;
    localparam logic [ADDR_W-1:0] A_CLR   = 8'h78;

    typedef enum logic [1:0] {
        MODE_IDLE0 = 2'd0,
        MODE_IDLE1 = 2'd1,
        MODE_OFF   = 2'd2,
        MODE_ON    = 2'd3
    } core_mode_e;

    typedef struct packed {
        logic [VREF_W-1:0] vref;
        logic [GAIN_W-1:0] gain;
        core_mode_e        mode;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] spread_nib(input logic [LEVELS-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < LEVELS; i++) r[i*NIB] = v[i];
        return r;
    endfunction

    function automatic logic [LEVELS-1:0] gather_nib(input logic [DATA_W-1:0] w);
        logic [LEVELS-1:0] r;
        for (int i = 0; i < LEVELS; i++) r[i] = w[i*NIB];
        return r;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.mode = core_mode_e'(w[1:0]);
        c.gain = w[GAIN_LSB +: GAIN_W];
        c.vref = w[VREF_LSB +: VREF_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[1:0] = c.mode;
        w[GAIN_LSB +: GAIN_W] = c.gain;
        w[VREF_LSB +: VREF_W] = c.vref;
        return w;
    endfunction
endpackage

// File: rtl/tt_level_detect.sv
module tt_level_detect #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_vld,
    input  logic              arm,
    input  logic [CODE_W-1:0] sample_code,
    input  logic [CODE_W-1:0] base_code,
    input  logic [CODE_W-1:0] offset_code,
    output logic              set_pulse,
    output logic              hot_q
);
    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0] trip_sum;
    logic             hot_now;

    always_comb begin
        trip_sum  = {1'b0, base_code} + {1'b0, offset_code};
        hot_now   = {1'b0, sample_code} > trip_sum;
        set_pulse = sample_vld && arm && hot_now && !hot_q;
    end

    always_ff @(posedge clk) begin
        if (rst)             hot_q <= 1'b0;
        else if (sample_vld) hot_q <= hot_now;
    end

    // R6: a trip can only come from a sample above the shared base
    a_r6_above_base: assert property (@(posedge clk) disable iff (rst)
        set_pulse |-> (sample_code > base_code));

    // R7: after a set, the level is remembered as hot
    a_r7_remember_hot: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> hot_q);
endmodule

// File: rtl/tt_irq_status.sv
module tt_irq_status #(
    parameter int LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] set_vec,
    input  logic [LEVELS-1:0] clr_vec,
    input  logic [LEVELS-1:0] en_vec,
    output logic [LEVELS-1:0] stat_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= set_vec | (stat_q & ~clr_vec);
    end

    assign irq = |(stat_q & en_vec);

    for (genvar g = 0; g < LEVELS; g++) begin : g_chk
        // R8: sticky unless cleared
        a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
            (stat_q[g] && !clr_vec[g]) |=> stat_q[g]);
        // R8: a set in the same cycle as a clear wins
        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[g] |=> stat_q[g]);
    end

    // R9: irq never rises without an enabled pending level
    a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((stat_q & en_vec) != '0));
endmodule

// File: rtl/tt_history.sv
module tt_history #(
    parameter int CODE_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic [CODE_W-1:0]            din,
    output logic [DEPTH-1:0][CODE_W-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst) taps[0] <= '0;
        else if (shift_en) taps[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) taps[g] <= '0;
            else if (shift_en) taps[g] <= taps[g-1];
        end
    end

    // R11: newest tap holds the sample just strobed
    a_r11_newest: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (taps[0] == $past(din)));

    // R11: no strobe, no movement
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps[DEPTH-1]));
endmodule

// File: rtl/thermal_trip_unit.sv
module thermal_trip_unit
    import thermtrip_pkg::*;
#(
    parameter int P_CODE_W = CODE_W,
    parameter int P_TRIM_W = TRIM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sense_ready,
    input  logic [P_TRIM_W-1:0] trim_word,
    input  logic [P_CODE_W-1:0] temp_code,
    input  logic                temp_vld,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wen,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);
    localparam int ADDR_STEP = 4;

    ctrl_t                  ctrl_q;
    logic [P_CODE_W-1:0]    thr_q;
    logic [P_CODE_W-1:0]    ofs_q [LEVELS];
    logic [LEVELS-1:0]      en_q;
    logic [P_CODE_W-1:0]    cur_q;

    logic                   cfg_we;
    logic                   core_on;
    logic [LEVELS-1:0]      eff_en;
    logic [LEVELS-1:0]      clr_vec;
    logic [LEVELS-1:0]      set_vec;
    logic [LEVELS-1:0]      hot_vec;
    logic [LEVELS-1:0]      stat_vec;
    logic [HIST_D-1:0][P_CODE_W-1:0] hist;

    assign cfg_we  = reg_wen && sense_ready;
    assign core_on = (ctrl_q.mode == MODE_ON);
    assign eff_en  = en_q & {LEVELS{core_on}};
    assign clr_vec = (reg_wen && reg_addr == A_CLR) ? gather_nib(reg_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            thr_q  <= '0;
            en_q   <= '0;
            for (int i = 0; i < LEVELS; i++) ofs_q[i] <= '0;
        end else if (cfg_we) begin
            if (reg_addr == A_CTRL) ctrl_q <= ctrl_unpack(reg_wdata);
            if (reg_addr == A_THR)  thr_q  <= reg_wdata[P_CODE_W-1:0];
            if (reg_addr == A_EN)   en_q   <= gather_nib(reg_wdata);
            for (int i = 0; i < LEVELS; i++)
                if (reg_addr == ADDR_W'(int'(A_OFS0) + ADDR_STEP*i))
                    ofs_q[i] <= reg_wdata[P_CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cur_q <= '0;
        else if (temp_vld) cur_q <= temp_code;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        tt_level_detect #(.CODE_W(P_CODE_W)) u_det (
            .clk         (clk),
            .rst         (rst),
            .sample_vld  (temp_vld),
            .arm         (core_on),
            .sample_code (temp_code),
            .base_code   (thr_q),
            .offset_code (ofs_q[g]),
            .set_pulse   (set_vec[g]),
            .hot_q       (hot_vec[g])
        );
    end

    tt_irq_status #(.LEVELS(LEVELS)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (eff_en),
        .stat_q  (stat_vec),
        .irq     (irq)
    );

    tt_history #(.CODE_W(P_CODE_W), .DEPTH(HIST_D)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (temp_vld),
        .din      (temp_code),
        .taps     (hist)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_TRIM: reg_rdata = DATA_W'(trim_word);
            A_CTRL: reg_rdata = ctrl_pack(ctrl_q);
            A_RDY:  reg_rdata = DATA_W'(sense_ready);
            A_CUR:  reg_rdata = DATA_W'(cur_q);
            A_THR:  reg_rdata = DATA_W'(thr_q);
            A_EN:   reg_rdata = spread_nib(eff_en);
            A_STAT: reg_rdata = spread_nib(stat_vec);
            default: begin
                for (int i = 0; i < LEVELS; i++)
                    if (reg_addr == ADDR_W'(int'(A_OFS0) + ADDR_STEP*i))
                        reg_rdata = DATA_W'(ofs_q[i]);
                for (int i = 0; i < HIST_D; i++)
                    if (reg_addr == ADDR_W'(int'(A_HIST0) + ADDR_STEP*i))
                        reg_rdata = DATA_W'(hist[i]);
            end
        endcase
    end

    // R3: configuration frozen while the sensor is not ready
    a_r3_locked_thr: assert property (@(posedge clk) disable iff (rst)
        !sense_ready |=> $stable(thr_q));
    a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (rst)
        !sense_ready |=> $stable(ctrl_q));

    // R10: core off keeps the interrupt line quiet
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !core_on |-> !irq);

    // R5: current code follows the strobe
    a_r5_cur_tracks: assert property (@(posedge clk) disable iff (rst)
        temp_vld |=> (cur_q == $past(temp_code)));

    // R7: no new status without a strobe
    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !temp_vld |=> ((stat_vec & ~$past(stat_vec)) == '0));
endmodule

// File: tb/thermal_trip_unit_tb_top.sv
module thermal_trip_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sense_ready = 1'b0;
    logic [15:0] trim_word = 16'h5A3C;
    logic [7:0]  temp_code = '0;
    logic        temp_vld = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    thermal_trip_unit dut_i (
        .clk(clk), .rst(rst), .sense_ready(sense_ready), .trim_word(trim_word),
        .temp_code(temp_code), .temp_vld(temp_vld), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference state
    int m_mode, m_gain, m_vref, m_thr, m_cur;
    int m_off[4], m_en[4], m_st[4], m_pv[4], m_past[4], n_st[4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] r;
        bit on;
        on = (m_mode == 3);
        r = 0;
        case (a)
            8'h00: r = {16'h0, trim_word};
            8'h20: r = (m_mode & 3) | (m_gain << 8) | (m_vref << 24);
            8'h28: r = {31'h0, sense_ready};
            8'h40: r = m_cur;
            8'h44: r = m_thr;
            8'h50: r = m_off[0];
            8'h54: r = m_off[1];
            8'h58: r = m_off[2];
            8'h5C: r = m_off[3];
            8'h60: r = m_past[0];
            8'h64: r = m_past[1];
            8'h68: r = m_past[2];
            8'h6C: r = m_past[3];
            8'h70: for (int i = 0; i < 4; i++) r[4*i] = on && m_en[i] != 0;
            8'h74: for (int i = 0; i < 4; i++) r[4*i] = m_st[i] != 0;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h28: return "R2";
            8'h20: return "R4";
            8'h60, 8'h64, 8'h68, 8'h6C: return "R11";
            8'h70: return "R10";
            8'h74: return "R7";
            default: return "R5";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_gain = 0; m_vref = 0; m_thr = 0; m_cur = 0;
            for (int i = 0; i < 4; i++) begin
                m_off[i] = 0; m_en[i] = 0; m_st[i] = 0; m_pv[i] = 0; m_past[i] = 0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit clr, hot, set;
                clr = reg_wen && reg_addr == 8'h78 && reg_wdata[4*i];
                hot = temp_vld && (int'(temp_code) > m_thr + m_off[i]);
                set = hot && !m_pv[i] && (m_mode == 3);
                n_st[i] = set ? 1 : (clr ? 0 : m_st[i]);
                if (temp_vld) m_pv[i] = hot;
            end
            if (reg_wen && sense_ready) begin
                case (reg_addr)
                    8'h20: begin
                        m_mode = reg_wdata[1:0];
                        m_gain = reg_wdata[11:8];
                        m_vref = reg_wdata[28:24];
                    end
                    8'h44: m_thr = reg_wdata[7:0];
                    8'h50: m_off[0] = reg_wdata[7:0];
                    8'h54: m_off[1] = reg_wdata[7:0];
                    8'h58: m_off[2] = reg_wdata[7:0];
                    8'h5C: m_off[3] = reg_wdata[7:0];
                    8'h70: for (int i = 0; i < 4; i++) m_en[i] = reg_wdata[4*i];
                    default: ;
                endcase
            end
            if (temp_vld) begin
                for (int i = 3; i > 0; i--) m_past[i] = m_past[i-1];
                m_past[0] = temp_code;
                m_cur = temp_code;
            end
            for (int i = 0; i < 4; i++) m_st[i] = n_st[i];
        end
        #1;
        if (!done) begin
            logic exp_irq;
            exp_irq = 0;
            for (int i = 0; i < 4; i++) if (m_st[i] && m_en[i] && m_mode == 3) exp_irq = 1;
            chk("R9 irq", {31'h0, irq}, {31'h0, exp_irq});
            chk(tag_of(reg_addr), reg_rdata, mread(reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1; temp_vld = 0;
    endtask

    task automatic smp(input logic [7:0] t);
        @(negedge clk);
        reg_wen = 0; temp_vld = 1; temp_code = t;
    endtask

    task automatic wr_smp(input logic [7:0] a, input logic [31:0] d, input logic [7:0] t);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1; temp_vld = 1; temp_code = t;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wen = 0; temp_vld = 0; reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    function automatic logic [7:0] addr_tab(input logic [3:0] k);
        case (k)
            4'd0: return 8'h00; 4'd1: return 8'h20; 4'd2: return 8'h28; 4'd3: return 8'h40;
            4'd4: return 8'h44; 4'd5: return 8'h50; 4'd6: return 8'h54; 4'd7: return 8'h58;
            4'd8: return 8'h5C; 4'd9: return 8'h60; 4'd10: return 8'h6C; 4'd11: return 8'h70;
            4'd12: return 8'h74; 4'd13: return 8'h78; 4'd14: return 8'h20; default: return 8'h7C;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        rd(8'h74, 32'h0, "R1 status");
        rd(8'h40, 32'h0, "R1 current");
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h00, 32'h5A3C, "R2 trim");
        rd(8'h28, 32'h0, "R2 not ready");
        wr(8'h44, 32'd50);
        rd(8'h44, 32'h0, "R3 locked threshold");
        sense_ready = 1;
        rd(8'h28, 32'h1, "R2 ready");
        wr(8'h20, 32'h1F00_0A03);
        rd(8'h20, 32'h1F00_0A03, "R4 control");
        wr(8'h44, 32'd80);
        wr(8'h50, 32'd0);
        wr(8'h54, 32'd10);
        wr(8'h58, 32'd20);
        wr(8'h5C, 32'd200);
        wr(8'h70, 32'h1111);
        rd(8'h70, 32'h1111, "R10 enables");
        rd(8'h5C, 32'd200, "R5 offset3");
        smp(8'd85);
        rd(8'h74, 32'h0001, "R7 level0 trip");
        chk("R9 irq on", {31'h0, irq}, 32'h1);
        rd(8'h40, 32'd85, "R5 current");
        smp(8'd90);
        rd(8'h74, 32'h0001, "R6 equal not hot");
        smp(8'd91);
        rd(8'h74, 32'h0011, "R6 one above");
        smp(8'd255);
        rd(8'h74, 32'h0111, "R6 no wrap level3");
        rd(8'h60, 32'd255, "R11 past0");
        rd(8'h64, 32'd91, "R11 past1");
        rd(8'h68, 32'd90, "R11 past2");
        rd(8'h6C, 32'd85, "R11 past3");
        wr(8'h78, 32'h0010);
        rd(8'h74, 32'h0101, "R8 partial clear");
        wr(8'h78, 32'h1111);
        rd(8'h74, 32'h0, "R8 clear all");
        chk("R9 irq off", {31'h0, irq}, 32'h0);
        smp(8'd10);
        wr_smp(8'h78, 32'h0001, 8'd85);
        rd(8'h74, 32'h0001, "R8 set wins");
        smp(8'd86);
        rd(8'h74, 32'h0001, "R7 no retrigger");
        wr(8'h20, 32'h2);
        rd(8'h70, 32'h0, "R10 core off enables");
        chk("R10 irq masked", {31'h0, irq}, 32'h0);
        smp(8'd10);
        smp(8'd95);
        rd(8'h74, 32'h0001, "R7 core off no set");
        wr(8'h20, 32'h3);
        rd(8'h70, 32'h1111, "R10 core on");
        chk("R9 irq back", {31'h0, irq}, 32'h1);
        wr(8'h78, 32'h1111);
        wr(8'h70, 32'h0100);
        smp(8'd10);
        smp(8'd85);
        rd(8'h74, 32'h0001, "R7 masked level");
        chk("R9 not enabled", {31'h0, irq}, 32'h0);
        rd(8'h7C, 32'h0, "R5 unmapped");
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                @(negedge clk);
                reg_addr = addr_tab(lf[3:0]);
                reg_wen = lf[4] & lf[5];
                reg_wdata = {lf, lf[7:0], lf[15:8]};
                temp_vld = lf[6];
                temp_code = lf[15:8];
                sense_ready = lf[7] | lf[8];
            end
        end
        @(negedge clk);
        reg_wen = 0; temp_vld = 0;
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule